// File: doc/BRIEF.md
# Two-Channel Cycle-Stealing DMA Controller

This block moves data between locations on a memory bus that it shares with a processor. It has two independent channels. Each channel keeps a 20-bit source base, a working source pointer, a destination pointer, a 16-bit transfer counter and a reload value for that counter. A channel performs one transfer for each request. A request comes from a software request bit or from the rising edge of the channel's interrupt line. One transfer moves either a byte or a 16-bit word. It reads the source into an internal latch in one bus cycle and writes the latch to the destination in the next bus cycle.

The controller always has priority over the processor. While a transfer is being arbitrated or is in progress, the processor grant is withheld, so each transfer takes its cycles from the processor. When requests arrive faster than transfers can complete, they collapse into a single pending bit. When the counter runs out, the channel disables itself, gives a one-cycle done pulse, and restores its counter from the reload value.

Top module: `dma2ch`

## Requirements
- R1: After reset every channel register reads 0. No channel is enabled, no bus read or write is driven, and `cpu_gnt_o` equals `cpu_req_i`.
- R2: Register address = {channel, offset}. Offsets are: 0 source (writing it loads both the source base and the working source pointer; reads return the base); 1 destination pointer; 2 reload value (writing it also loads the counter); 3 control; 4 counter (read only); 5 working source pointer (read only). Control bits: 0 enable, 1 word size, 2 source increment, 3 destination increment, 4 software request (write only, reads 0).
- R3: A request is accepted when a control write has bit 4 set and the written enable bit is 1, or on a rising edge of the channel's `irq_i` bit while the channel is enabled. A request made while the channel is disabled has no effect on the bus, the pointers or the counter.
- R4: When a request is accepted at clock edge e0, the cycle after e0 is an arbitration cycle. In the next cycle (after e1) the block drives a read of the working source pointer. In the cycle after that (after e2) it drives a write of the latched data to the destination pointer.
- R5: `cpu_gnt_o` is 0 during the arbitration, read and write cycles of a transfer. At all other times it follows `cpu_req_i`.
- R6: In word mode the block moves 16 bits and each enabled pointer steps by 2. In byte mode it moves the low 8 bits, writes upper byte 0, and each enabled pointer steps by 1. A pointer whose increment bit is 0 stays fixed.
- R7: The counter decrements by one per transfer. On the transfer that finds the counter at 1 (or 0), the block does three things: it reloads the counter from the reload value, clears the enable bit, and raises `done_o` for exactly one cycle, the cycle after the write cycle.
- R8: Requests that arrive while a request is already pending are merged with it. A request accepted in the same cycle that the pending bit is taken for service sets the pending bit again. Three requests on consecutive cycles therefore produce exactly two transfers.
- R9: When both channels are pending in the same arbitration cycle, channel 0 is serviced first, and channel 1 follows right after.
- R10: The pointers keep their advanced values after the counter runs out. The working source pointer reads as base + transfers × step × source-increment bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | {channel, offset} register address |
| reg_wdata_i | input | 20 | Register write data |
| reg_rdata_o | output | 20 | Register read data (combinational) |
| irq_i | input | 2 | Per-channel interrupt request, edge detected |
| cpu_req_i | input | 1 | Processor bus request |
| cpu_gnt_o | output | 1 | Processor bus grant |
| mem_rd_o | output | 1 | DMA read cycle |
| mem_we_o | output | 1 | DMA write cycle |
| mem_word_o | output | 1 | 1 = 16-bit access, 0 = byte |
| mem_addr_o | output | 20 | DMA bus address |
| mem_wdata_o | output | 16 | DMA write data |
| mem_rdata_i | input | 16 | Read data, valid in the read cycle |
| done_o | output | 2 | Per-channel terminal-count pulse |

## Verification
When a request is taken at edge e0, results are due as follows:
- Cycle after e0: the processor grant drops.
- Cycle after e1: the source read is on the bus.
- Cycle after e2: the destination write is on the bus.
- Cycle after e3: the grant returns, the pointers and counter have been updated, and a terminal transfer shows its done pulse.

Register read-back is combinational. The bench drives every input at a falling edge and samples one time unit later, in the cycle named above for each result. Between random transfers it waits five cycles, so memory, pointers and counters are compared only after the write edge has settled.

// File: rtl/dma2ch_pkg.sv
package dma2ch_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} dma_state_t;

  localparam logic [2:0] OFF_SRC  = 3'd0;
  localparam logic [2:0] OFF_DST  = 3'd1;
  localparam logic [2:0] OFF_RLD  = 3'd2;
  localparam logic [2:0] OFF_CTRL = 3'd3;
  localparam logic [2:0] OFF_CNT  = 3'd4;
  localparam logic [2:0] OFF_FWD  = 3'd5;

  localparam int CB_EN   = 0;
  localparam int CB_WORD = 1;
  localparam int CB_SINC = 2;
  localparam int CB_DINC = 3;
  localparam int CB_SWRQ = 4;
endpackage

// File: rtl/dma2ch_chan.sv
module dma2ch_chan
  import dma2ch_pkg::*;
#(
  parameter int AW = 20,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [2:0]    addr_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          irq_i,
  input  logic          grant_i,
  input  logic          fin_i,
  output logic          pend_o,
  output logic          word_o,
  output logic          done_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [AW-1:0] rdata_o
);
  logic [AW-1:0] base_q, fwd_q, dst_q;
  logic [CW-1:0] reload_q, cnt_q;
  logic          en_q, word_q, sinc_q, dinc_q, pend_q, irq_q, done_q;
  logic          wr_ctrl, req, term, en_nxt;
  logic [AW-1:0] step;

  assign wr_ctrl = wr_i && (addr_i == OFF_CTRL);
  assign req     = (wr_ctrl && wdata_i[CB_SWRQ]) || (irq_i && !irq_q);
  assign term    = (cnt_q <= CW'(1));
  assign step    = word_q ? AW'(2) : AW'(1);

  always_comb begin
    en_nxt = en_q;
    if (wr_ctrl)            en_nxt = wdata_i[CB_EN];
    else if (fin_i && term) en_nxt = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0; fwd_q <= '0; dst_q <= '0;
      reload_q <= '0; cnt_q <= '0;
      en_q <= 1'b0; word_q <= 1'b0; sinc_q <= 1'b0; dinc_q <= 1'b0;
      pend_q <= 1'b0; irq_q <= 1'b0; done_q <= 1'b0;
    end else begin
      irq_q  <= irq_i;
      done_q <= fin_i && term;
      en_q   <= en_nxt;
      // set wins over service so a late request is not lost
      if (!en_nxt)      pend_q <= 1'b0;
      else if (req)     pend_q <= 1'b1;
      else if (grant_i) pend_q <= 1'b0;

      if (wr_i && addr_i == OFF_SRC) begin
        base_q <= wdata_i;
        fwd_q  <= wdata_i;
      end else if (fin_i && sinc_q) fwd_q <= fwd_q + step;

      if (wr_i && addr_i == OFF_DST)  dst_q <= wdata_i;
      else if (fin_i && dinc_q)       dst_q <= dst_q + step;

      if (wr_i && addr_i == OFF_RLD) begin
        reload_q <= wdata_i[CW-1:0];
        cnt_q    <= wdata_i[CW-1:0];
      end else if (fin_i) cnt_q <= term ? reload_q : cnt_q - 1'b1;

      if (wr_ctrl) begin
        word_q <= wdata_i[CB_WORD];
        sinc_q <= wdata_i[CB_SINC];
        dinc_q <= wdata_i[CB_DINC];
      end
    end
  end

  always_comb begin
    case (addr_i)
      OFF_SRC:  rdata_o = base_q;
      OFF_DST:  rdata_o = dst_q;
      OFF_RLD:  rdata_o = AW'(reload_q);
      OFF_CTRL: rdata_o = AW'({dinc_q, sinc_q, word_q, en_q});
      OFF_CNT:  rdata_o = AW'(cnt_q);
      OFF_FWD:  rdata_o = fwd_q;
      default:  rdata_o = '0;
    endcase
  end

  assign pend_o = pend_q;
  assign word_o = word_q;
  assign done_o = done_q;
  assign src_o  = fwd_q;
  assign dst_o  = dst_q;

  AST_DONE_AFTER_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(en_q)); // R7
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_i && !term && !wr_i) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R7
  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !wr_i) |=> !pend_q); // R3
endmodule

// File: rtl/dma2ch_arb.sv
module dma2ch_arb
  import dma2ch_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] pend_i,
  output dma_state_t     state_o,
  output logic [CHW-1:0] sel_o,
  output logic           start_o,
  output logic [NCH-1:0] grant_o,
  output logic [NCH-1:0] fin_o
);
  dma_state_t     state_q;
  logic [CHW-1:0] sel_q, nsel;

  // lowest index wins
  always_comb begin
    nsel = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend_i[i]) nsel = CHW'(i);
  end

  assign start_o = (state_q == ST_IDLE) && (|pend_i);
  assign grant_o = start_o ? (NCH'(1) << nsel) : '0;
  assign fin_o   = (state_q == ST_WR) ? (NCH'(1) << sel_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_o) begin
          state_q <= ST_RD;
          sel_q   <= nsel;
        end
        ST_RD:   state_q <= ST_WR;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign sel_o   = sel_q;

  AST_RD_THEN_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD) |=> (state_q == ST_WR)); // R4
  AST_LOW_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && pend_i[0]) |=> (state_q == ST_RD && sel_q == '0)); // R9
  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o)); // R9
endmodule

// File: rtl/dma2ch.sv
module dma2ch
  import dma2ch_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 20,
  parameter int CW  = 16,
  parameter int DW  = 16,
  localparam int CHW = $clog2(NCH),
  localparam int RAW = CHW + 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic [RAW-1:0] reg_addr_i,
  input  logic [AW-1:0]  reg_wdata_i,
  output logic [AW-1:0]  reg_rdata_o,
  input  logic [NCH-1:0] irq_i,
  input  logic           cpu_req_i,
  output logic           cpu_gnt_o,
  output logic           mem_rd_o,
  output logic           mem_we_o,
  output logic           mem_word_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic [NCH-1:0] done_o
);
  logic [NCH-1:0] pend, word, grant, fin;
  logic [AW-1:0]  src [NCH];
  logic [AW-1:0]  dst [NCH];
  logic [AW-1:0]  rdat [NCH];
  dma_state_t     state;
  logic [CHW-1:0] sel, rch;
  logic           start;
  logic [DW-1:0]  latch_q;

  assign rch = reg_addr_i[RAW-1:3];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma2ch_chan #(.AW(AW), .CW(CW)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (reg_we_i && rch == CHW'(c)),
      .addr_i  (reg_addr_i[2:0]),
      .wdata_i (reg_wdata_i),
      .irq_i   (irq_i[c]),
      .grant_i (grant[c]),
      .fin_i   (fin[c]),
      .pend_o  (pend[c]),
      .word_o  (word[c]),
      .done_o  (done_o[c]),
      .src_o   (src[c]),
      .dst_o   (dst[c]),
      .rdata_o (rdat[c])
    );
  end

  dma2ch_arb #(.NCH(NCH)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pend_i  (pend),
    .state_o (state),
    .sel_o   (sel),
    .start_o (start),
    .grant_o (grant),
    .fin_o   (fin)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              latch_q <= '0;
    else if (state == ST_RD)  latch_q <= word[sel] ? mem_rdata_i : DW'(mem_rdata_i[7:0]);
  end

  assign reg_rdata_o = rdat[rch];
  assign cpu_gnt_o   = cpu_req_i && state == ST_IDLE && !start;
  assign mem_rd_o    = (state == ST_RD);
  assign mem_we_o    = (state == ST_WR);
  assign mem_word_o  = (state != ST_IDLE) && word[sel];
  assign mem_addr_o  = (state == ST_RD) ? src[sel] : (state == ST_WR) ? dst[sel] : '0;
  assign mem_wdata_o = (state == ST_WR) ? latch_q : '0;

  AST_CPU_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_we_o) |-> !cpu_gnt_o); // R5
  AST_WRITE_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(mem_rd_o)); // R4
  AST_BUS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_we_o)); // R4
endmodule

// File: tb/sim_dma2ch.sv
module sim_dma2ch;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [19:0] reg_wdata = '0, reg_rdata;
  logic [1:0]  irq = '0, done;
  logic        cpu_req = 1'b0, cpu_gnt;
  logic        mem_rd, mem_we, mem_word;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  logic [7:0]  mem   [1024];
  logic [7:0]  model [1024];
  int          n_chk = 0, n_fail = 0, rd_cnt = 0;
  int          dn_cnt [2];

  always #2.5 clk = ~clk;

  dma2ch u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_i(irq),
    .cpu_req_i(cpu_req), .cpu_gnt_o(cpu_gnt), .mem_rd_o(mem_rd), .mem_we_o(mem_we),
    .mem_word_o(mem_word), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .done_o(done)
  );

  assign mem_rdata = {mem[mem_addr[9:0] + 10'd1], mem[mem_addr[9:0]]};

  function automatic logic [7:0] pat(int i);
    return 8'(i * 37 + 5);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= pat(i);
      rd_cnt <= 0; dn_cnt[0] <= 0; dn_cnt[1] <= 0;
    end else begin
      if (mem_we) begin
        mem[mem_addr[9:0]] <= mem_wdata[7:0];
        if (mem_word) mem[mem_addr[9:0] + 10'd1] <= mem_wdata[15:8];
      end
      if (mem_rd) rd_cnt <= rd_cnt + 1;
      for (int c = 0; c < 2; c++) if (done[c]) dn_cnt[c] <= dn_cnt[c] + 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [19:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [19:0] v);
    @(negedge clk); reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic sync_model();
    for (int i = 0; i < 1024; i++) model[i] = mem[i];
  endtask

  function automatic int mem_diff();
    int d = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== model[i]) d++;
    return d;
  endfunction

  task automatic setup(bit ch, int s, int d, int n, logic [3:0] ctl);
    wr({ch, 3'd0}, 20'(s));
    wr({ch, 3'd1}, 20'(d));
    wr({ch, 3'd2}, 20'(n));
    wr({ch, 3'd3}, {16'h0, ctl});
  endtask

  task automatic run_xfer(bit ch, int s, int d, int n, bit wd, bit si, bit di, bit use_irq);
    logic [19:0] v;
    int step = wd ? 2 : 1;
    int d0 = dn_cnt[ch];
    setup(ch, s, d, n, {di, si, wd, 1'b1});
    for (int i = 0; i < n; i++) begin
      int sa = (s + i * step * si) % 1024;
      int da = (d + i * step * di) % 1024;
      if (use_irq) begin
        @(negedge clk); irq[ch] = 1'b1;
        @(negedge clk); irq[ch] = 1'b0;
      end else wr({ch, 3'd3}, {15'h0, 1'b1, di, si, wd, 1'b1});
      repeat (5) @(negedge clk);
      model[da] = model[sa];
      if (wd) model[(da + 1) % 1024] = model[(sa + 1) % 1024];
    end
    chk("R6 memory contents", mem_diff(), 0);
    rd({ch, 3'd4}, v); chk("R7 counter reloaded", v, 20'(n));
    rd({ch, 3'd3}, v); chk("R7 enable cleared", v[0], 0);
    chk("R7 one done pulse", dn_cnt[ch] - d0, 1);
    rd({ch, 3'd5}, v); chk("R10 source pointer", v, 20'(s + n * step * si));
    rd({ch, 3'd1}, v); chk("R10 dest pointer", v, 20'(d + n * step * di));
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [19:0] v;
    int r0;
    logic [15:0] expw;
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); sync_model();

    // R1 reset state
    for (int c = 0; c < 2; c++)
      for (int o = 0; o < 6; o++) begin
        rd({c[0], o[2:0]}, v); chk("R1 register zero", v, 0);
      end
    cpu_req = 1'b1; #1;
    chk("R1 grant follows request", cpu_gnt, 1);
    chk("R1 no bus cycle", {mem_rd, mem_we}, 0);
    cpu_req = 1'b0; #1;
    chk("R1 grant follows request low", cpu_gnt, 0);

    // R3 disabled channel ignores requests
    setup(1'b1, 40, 600, 4, 4'b0110);
    r0 = rd_cnt;
    wr(4'h8 | 4'd3, 20'h00016);
    @(negedge clk); irq[1] = 1'b1; @(negedge clk); irq[1] = 1'b0;
    repeat (6) @(negedge clk);
    chk("R3 no bus cycle when disabled", rd_cnt - r0, 0);
    rd(4'hC, v); chk("R3 counter untouched", v, 4);
    rd(4'hD, v); chk("R3 pointer untouched", v, 40);
    chk("R3 memory untouched", mem_diff(), 0);

    // R4 R5 R2 cycle timing under cycle stealing
    setup(1'b0, 100, 700, 3, 4'b1111);
    cpu_req = 1'b1;
    expw = {model[101], model[100]};
    wr(4'd3, 20'h0001F);
    #1;
    chk("R5 grant low in arbitration", cpu_gnt, 0);
    chk("R4 no bus in arbitration", {mem_rd, mem_we}, 0);
    @(negedge clk); #1;
    chk("R4 read cycle", {mem_rd, mem_we}, 2'b10);
    chk("R4 read address", mem_addr, 100);
    chk("R5 grant low in read", cpu_gnt, 0);
    @(negedge clk); #1;
    chk("R4 write cycle", {mem_rd, mem_we}, 2'b01);
    chk("R4 write address", mem_addr, 700);
    chk("R6 word write data", mem_wdata, expw);
    chk("R5 grant low in write", cpu_gnt, 0);
    @(negedge clk); #1;
    chk("R5 grant back", cpu_gnt, 1);
    chk("R7 no done before terminal", done[0], 0);
    cpu_req = 1'b0;
    rd(4'd4, v); chk("R7 counter decrement", v, 2);
    rd(4'd0, v); chk("R2 source base kept", v, 100);
    rd(4'd5, v); chk("R10 working source advanced", v, 102);

    // R8 merged requests: three on consecutive cycles
    setup(1'b0, 200, 800, 5, 4'b1111);
    r0 = rd_cnt;
    @(negedge clk); reg_we = 1'b1; reg_addr = 4'd3; reg_wdata = 20'h0001F;
    repeat (3) @(negedge clk);
    reg_we = 1'b0;
    repeat (10) @(negedge clk);
    chk("R8 two transfers", rd_cnt - r0, 2);
    rd(4'd4, v); chk("R8 counter after merge", v, 3);

    // R9 simultaneous requests
    setup(1'b0, 300, 900, 4, 4'b0111);
    setup(1'b1, 350, 950, 4, 4'b0111);
    @(negedge clk); irq = 2'b11;
    @(negedge clk); irq = 2'b00;
    @(negedge clk); #1;
    chk("R9 channel 0 read first", mem_addr, 300);
    repeat (3) @(negedge clk); #1;
    chk("R9 channel 1 follows", mem_addr, 350);
    chk("R9 channel 1 read cycle", mem_rd, 1);
    repeat (4) @(negedge clk);
    sync_model();

    // R7 terminal count directed: single transfer, byte, fixed pointers
    run_xfer(1'b1, 11, 611, 1, 1'b0, 1'b0, 1'b0, 1'b0);

    // random transfers: R6 R7 R10
    for (int t = 0; t < 24; t++) begin
      bit  ch = 1'($urandom % 2);
      bit  wd = 1'($urandom % 2);
      int  s  = int'($urandom % 190) * 2;
      int  d  = 512 + int'($urandom % 190) * 2;
      int  n  = 1 + int'($urandom % 6);
      run_xfer(ch, s, d, n, wd, 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule